// File: doc/BRIEF.md
# Pulse-Width Speed Error Detector

This block produces the speed error for a digital speed-regulation loop. It compares a reference pulse train, made inside the block by dividing the system clock, with a feedback pulse train made from a rotary encoder. It counts the high time of each train in system clock cycles and subtracts the reference count from the feedback count. A digital loop filter can take the signed result as it is.

The reference generator toggles its output each time a programmable terminal count is reached, which sets the reference speed. The encoder input is brought into the clock domain by two flip-flops. Its rising edges drive a programmable divide-by-N stage, so the loop can hold the motor at a multiple of the reference rate. The feedback width is wider when the motor runs slow, so a slow motor gives a positive error, and a positive error should raise the drive duty cycle. A width counter stops at its maximum value. A stalled or very slow motor therefore gives a bounded error and not a wrapped one.

Top module: `swd_top`

## Requirements
- R1: While reset is high, and in the cycle after it, `err_o` is zero and `err_valid_o` is low. Reset clears every counter and divider.
- R2: The reference level stays high for exactly `ref_div_i` clock cycles and low for the same count. A value of 0 acts as 1.
- R3: The divided feedback level toggles on every N-th synchronized rising edge of `enc_i`, where N is `fb_div_i`. Its high time is therefore N encoder periods. A value of 0 acts as 1.
- R4: `err_o` equals the feedback high width minus the reference high width, both counted in clock cycles, as a two's-complement value of CNT_W+1 bits. It is zero when the two widths match and positive when the feedback pulse is wider.
- R5: `err_valid_o` is high for exactly one cycle for each measured feedback pulse, so successive strobes are one divided feedback period apart. `err_o` keeps its value in every cycle where the strobe is low.
- R6: A width count stops at 2^CNT_W-1. A pulse that reaches this value is reported once, as the maximum width, in the cycle it saturates. Its falling edge then produces no second report.
- R7: The subtraction uses the most recently completed reference width. A change of `ref_div_i` without a reset is reflected in later errors.
- R8: The magnitude of `err_o` never exceeds 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_i | input | 1 | Raw encoder pulse, asynchronous |
| ref_div_i | input | REF_DIV_W | Reference half-period in clock cycles |
| fb_div_i | input | FB_DIV_W | Encoder divide factor N |
| err_o | output | CNT_W+1 | Signed speed error, feedback minus reference |
| err_valid_o | output | 1 | One-cycle strobe marking a new error |

## Verification
The assertions check properties that hold in every cycle: the cleared state after reset, the single-cycle strobe, that the error keeps its value between strobes, and that the error stays within its range. The values themselves can only be shown by the bench scenarios. These cover matched, slow and fast feedback; several divide factors, including zero; a reference change with no reset; a saturating feedback pulse; and the most negative reachable error. The scoreboard also checks the spacing between strobes, and this spacing would expose a second report after a saturated pulse.

// File: rtl/swd_pkg.sv
package swd_pkg;

    // Edge pair produced from a current and a delayed level
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    // Index of each measured train inside the meter array
    typedef enum int {
        TRAIN_REF = 0,
        TRAIN_FB  = 1
    } train_e;

    localparam int NUM_TRAINS = 2;

    function automatic edge_pair_t find_edges(input logic now_v, input logic prev_v);
        edge_pair_t e;
        e.rise = now_v & ~prev_v;
        e.fall = ~now_v & prev_v;
        return e;
    endfunction

endpackage

// File: rtl/swd_sync.sv
module swd_sync
    import swd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       async_i,
    output edge_pair_t edges_o
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign edges_o = find_edges(s2_q, s3_q);
endmodule

// File: rtl/swd_toggle_div.sv
module swd_toggle_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic [W-1:0] term_i,
    output logic         lvl_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] last_idx;

    // a terminal value of zero behaves like one
    assign last_idx = (term_i == '0) ? '0 : term_i - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lvl_o <= 1'b0;
        end else if (step_i) begin
            if (cnt_q >= last_idx) begin
                cnt_q <= '0;
                lvl_o <= ~lvl_o;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/swd_width_meter.sv
module swd_width_meter
    import swd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl_i,
    output logic [CNT_W-1:0] width_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] TOP_V  = '1;
    localparam logic [CNT_W-1:0] NEAR_V = TOP_V - 1'b1;

    logic             lvl_q;
    logic             sat_q;
    logic [CNT_W-1:0] cnt_q;
    edge_pair_t       ed;

    assign ed = find_edges(lvl_i, lvl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= 1'b0;
            sat_q   <= 1'b0;
            cnt_q   <= '0;
            width_o <= '0;
            done_o  <= 1'b0;
        end else begin
            lvl_q  <= lvl_i;
            done_o <= 1'b0;
            if (lvl_i) begin
                if (cnt_q != TOP_V) begin
                    cnt_q <= cnt_q + 1'b1;
                end
                if (cnt_q == NEAR_V) begin
                    width_o <= TOP_V;
                    done_o  <= 1'b1;
                    sat_q   <= 1'b1;
                end
            end else begin
                cnt_q <= '0;
                sat_q <= 1'b0;
                if (ed.fall && !sat_q) begin
                    width_o <= cnt_q;
                    done_o  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/swd_top.sv
module swd_top
    import swd_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int REF_DIV_W = 16,
    parameter int FB_DIV_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enc_i,
    input  logic [REF_DIV_W-1:0] ref_div_i,
    input  logic [FB_DIV_W-1:0]  fb_div_i,
    output logic signed [CNT_W:0] err_o,
    output logic                 err_valid_o
);
    localparam int ERR_W = CNT_W + 1;

    edge_pair_t       enc_ed;
    logic             ref_lvl;
    logic             fb_lvl;
    logic             lvl_arr   [NUM_TRAINS];
    logic [CNT_W-1:0] width_arr [NUM_TRAINS];
    logic             done_arr  [NUM_TRAINS];
    logic signed [ERR_W-1:0] diff;

    swd_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (enc_i),
        .edges_o (enc_ed)
    );

    swd_toggle_div #(.W(REF_DIV_W)) u_ref_gen (
        .clk    (clk),
        .rst    (rst),
        .step_i (1'b1),
        .term_i (ref_div_i),
        .lvl_o  (ref_lvl)
    );

    swd_toggle_div #(.W(FB_DIV_W)) u_fb_div (
        .clk    (clk),
        .rst    (rst),
        .step_i (enc_ed.rise),
        .term_i (fb_div_i),
        .lvl_o  (fb_lvl)
    );

    assign lvl_arr[TRAIN_REF] = ref_lvl;
    assign lvl_arr[TRAIN_FB]  = fb_lvl;

    for (genvar g = 0; g < NUM_TRAINS; g++) begin : g_meter
        swd_width_meter #(.CNT_W(CNT_W)) u_meter (
            .clk     (clk),
            .rst     (rst),
            .lvl_i   (lvl_arr[g]),
            .width_o (width_arr[g]),
            .done_o  (done_arr[g])
        );
    end

    assign diff = $signed({1'b0, width_arr[TRAIN_FB]}) - $signed({1'b0, width_arr[TRAIN_REF]});

    always_ff @(posedge clk) begin
        if (rst) begin
            err_o       <= '0;
            err_valid_o <= 1'b0;
        end else begin
            err_valid_o <= done_arr[TRAIN_FB];
            if (done_arr[TRAIN_FB]) begin
                err_o <= diff;
            end
        end
    end
endmodule

// File: rtl/swd_top_chk.sv
module swd_top_chk #(
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic signed [CNT_W:0] err_o,
    input logic                  err_valid_o
);
    localparam int LIM = (1 << CNT_W) - 1;

    logic seen1_q = 1'b0;
    logic seen2_q = 1'b0;

    always_ff @(posedge clk) begin
        seen1_q <= seen1_q | rst;
        seen2_q <= seen1_q;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (err_o == '0 && !err_valid_o));

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid_o |=> !err_valid_o);

    // R5
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (seen2_q && !err_valid_o) |-> $stable(err_o));

    // R8
    err_range_chk: assert property (@(posedge clk) disable iff (rst)
        seen2_q |-> ((int'(err_o) <= LIM) && (int'(err_o) >= -LIM)));
endmodule

bind swd_top swd_top_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .err_o       (err_o),
    .err_valid_o (err_valid_o)
);

// File: tb/swd_top_test.sv
`timescale 1ns/1ps
module swd_top_test;
    localparam int CNT_W     = 10;
    localparam int REF_DIV_W = 16;
    localparam int FB_DIV_W  = 8;
    localparam int MAXW      = (1 << CNT_W) - 1;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  enc = 1'b0;
    logic [REF_DIV_W-1:0]  ref_div = 16'd40;
    logic [FB_DIV_W-1:0]   fb_div  = 8'd2;
    logic signed [CNT_W:0] err;
    logic                  err_valid;

    int enc_half = 10;

    // scoreboard state
    int    exp_q[$];
    bit    armed   = 1'b0;
    int    arm_gen = 0;
    int    exp_gap = 0;
    string cur_tag = "";

    int drv_checks = 0, drv_fails = 0;
    int mon_checks = 0, mon_fails = 0;
    bit done_flag = 1'b0;

    swd_top #(.CNT_W(CNT_W), .REF_DIV_W(REF_DIV_W), .FB_DIV_W(FB_DIV_W)) uut (
        .clk         (clk),
        .rst         (rst),
        .enc_i       (enc),
        .ref_div_i   (ref_div),
        .fb_div_i    (fb_div),
        .err_o       (err),
        .err_valid_o (err_valid)
    );

    always #2 clk = ~clk;

    // encoder source: period 2*enc_half clocks, half high
    initial begin
        forever begin
            enc = 1'b1;
            repeat (enc_half) @(negedge clk);
            enc = 1'b0;
            repeat (enc_half) @(negedge clk);
        end
    end

    // monitor: pops expected errors and checks strobe spacing
    initial begin
        int cyc = 0;
        int last_cyc = 0;
        int seen_gen = -1;
        forever begin
            @(negedge clk);
            cyc++;
            if (armed && err_valid) begin
                mon_checks++;
                if (exp_q.size() == 0) begin
                    mon_fails++;
                    $display("FAIL R5 %s unexpected strobe err=%0d expected=none", cur_tag, err);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (int'(err) != e) begin
                        mon_fails++;
                        $display("FAIL %s err=%0d expected=%0d", cur_tag, err, e);
                    end
                end
                if (seen_gen == arm_gen) begin
                    mon_checks++;
                    if (cyc - last_cyc != exp_gap) begin
                        mon_fails++;
                        $display("FAIL R5 %s strobe gap=%0d expected=%0d", cur_tag, cyc - last_cyc, exp_gap);
                    end
                end
                seen_gen = arm_gen;
                last_cyc = cyc;
            end
        end
    end

    task automatic apply_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        drv_checks++;
        if (err != '0 || err_valid != 1'b0) begin
            drv_fails++;
            $display("FAIL R1 reset err=%0d valid=%0b expected=0/0", err, err_valid);
        end
        rst = 1'b0;
        @(negedge clk);
        drv_checks++;
        if (err != '0 || err_valid != 1'b0) begin
            drv_fails++;
            $display("FAIL R1 after reset err=%0d valid=%0b expected=0/0", err, err_valid);
        end
    endtask

    // driver: sets up a case, pushes expected errors, waits for them to drain
    task automatic run_case(input int rd, input int nd, input int hh, input int exp_err,
                            input bit do_reset, input string tag);
        int n_eff;
        int r_eff;
        n_eff = (nd == 0) ? 1 : nd;
        r_eff = (rd == 0) ? 1 : rd;
        ref_div  = REF_DIV_W'(rd);
        fb_div   = FB_DIV_W'(nd);
        enc_half = hh;
        if (do_reset) apply_reset();
        repeat (4 * (r_eff + 1) + 8 * n_eff * hh + 40) @(negedge clk);
        cur_tag = tag;
        exp_gap = 4 * n_eff * hh;
        for (int k = 0; k < 3; k++) exp_q.push_back(exp_err);
        arm_gen++;
        armed = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        armed = 1'b0;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d",
                 drv_checks + mon_checks, drv_fails + mon_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            drv_checks++;
            drv_fails++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        // R4 matched widths: 40 vs 2*2*10
        run_case(40, 2, 10, 0, 1'b1, "R4 matched speed");
        // R7 reference changed without reset: 40 - 30
        run_case(30, 2, 10, 10, 1'b0, "R7 new reference width");
        // R4 slow motor, wider feedback: 60 - 40
        run_case(40, 2, 15, 20, 1'b1, "R4 slow motor positive");
        // R4 fast motor: 20 - 40
        run_case(40, 2, 5, -20, 1'b1, "R4 fast motor negative");
        // R3 divide by four: 4*10 = 40
        run_case(40, 4, 5, 0, 1'b1, "R3 divide by four");
        // R3 divide by one: 1*40 = 40
        run_case(40, 1, 20, 0, 1'b1, "R3 divide by one");
        // R3 zero divide acts as one
        run_case(40, 0, 20, 0, 1'b1, "R3 zero divide");
        // R2 long reference: 100 vs 2*50
        run_case(100, 2, 25, 0, 1'b1, "R2 long reference");
        // R2 zero reference acts as one: 2 - 1
        run_case(0, 1, 1, 1, 1'b1, "R2 zero reference");
        // R8 most negative: 2 - 1000
        run_case(1000, 1, 1, -998, 1'b1, "R8 large negative");
        // R6 saturation: 1600 high clamps to 1023, minus 40
        run_case(40, 1, 800, MAXW - 40, 1'b1, "R6 saturated feedback");
        // R1 reset clears a nonzero error
        apply_reset();
        done_flag = 1'b1;
        report();
        $finish;
    end
endmodule